// File: doc/BRIEF.md
# Pipelined Integer Square Root Array

This block returns the integer square root and the remainder of an unsigned radicand of `RAD_W` bits (an even number, 2n). It is built as a fully pipelined digit-by-digit array with n rows. Each row handles one root bit. It brings in the next two radicand bits, counting down from the top, below the running remainder. It then tries to subtract a trial value made by placing binary `01` after the root bits already found.

Each row is a chain of controlled subtract-multiplex cells. The borrow that leaves the top of the chain picks the result for every cell in the row. With no borrow, the difference becomes the new remainder and the root bit is 1. With a borrow, the remainder passes through as it was and the root bit is 0. The array contains no adder and never uses an `11` append.

Each row registers its state, so a new radicand can be accepted on every clock. Bubbles in the input stream come out as bubbles in the result stream. There is no stall.

Top module: `sqrt_pipe`

## Requirements
- R1: For every qualified input, `out_root` equals floor(sqrt(`in_rad`)) as an unsigned value of `RAD_W/2` bits.
- R2: `out_rem` equals `in_rad` minus `out_root` squared, so that `out_root`² + `out_rem` reproduces the radicand exactly.
- R3: A result leaves exactly `RAD_W/2` clock cycles after its radicand is sampled with `in_valid` high. A new radicand may be presented on every cycle, and results keep their input order.
- R4: The remainder never exceeds 2·`out_root`, so `RAD_W/2+1` bits hold it. Every row before the last hands on a remainder below 2^(`RAD_W/2`).
- R5: A cycle with `in_valid` low produces a cycle with `out_valid` low exactly `RAD_W/2` cycles later. No result appears that was not requested.
- R6: While the synchronous active-high `rst` is high, every valid stage is cleared, whatever `in_valid` does. After release, `out_valid` stays low until the first radicand presented after reset has crossed the pipeline.
- R7: A radicand of 0 gives root 0 and remainder 0. A radicand of all ones gives root 2^(`RAD_W/2`)−1 and remainder 2^(`RAD_W/2`+1)−2.
- R8: A perfect square k² gives root k and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | Marks `in_rad` as a radicand to process this cycle |
| in_rad | input | RAD_W | Unsigned radicand |
| out_valid | output | 1 | Marks `out_root` and `out_rem` as a result |
| out_root | output | RAD_W/2 | Integer square root |
| out_rem | output | RAD_W/2+1 | Radicand minus root squared |

## Verification
The checker assumes that `in_valid` and `in_rad` are known (not X) on every rising edge outside reset. It also assumes that the data of a valid beat is whatever is on `in_rad` at that edge. The identity and latency properties compare against the checker's own delay line of those sampled values.

The bench drives every input at the falling edge, so each value is settled well before the edge that samples it. It holds `in_valid` at a defined level at all times, including during reset. That reset-time traffic must vanish, and nothing is expected from it.

The stimulus streams back to back and also inserts idle cycles. This covers both full occupancy and bubbles inside the array. Because the pipeline never stalls, no backpressure case needs modelling.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;

  // Result of one controlled subtract-multiplex bit cell.
  typedef struct packed {
    logic d;   // selected output bit
    logic bo;  // borrow out of the subtract half
  } csm_out_t;

  // Bit cell: subtract x - y - b, then keep the difference when keep_x is 0
  // or pass x unchanged when keep_x is 1. The borrow is independent of keep_x.
  function automatic csm_out_t csm_eval(input logic x, input logic y,
                                        input logic b, input logic keep_x);
    csm_out_t r;
    logic     diff;
    diff = x ^ y ^ b;
    r.bo = (~x & (y | b)) | (y & b);
    r.d  = keep_x ? x : diff;
    return r;
  endfunction

  // Trial value for one row: partial root followed by binary 01.
  function automatic logic [63:0] trial_of(input logic [63:0] root);
    return {root[61:0], 2'b01};
  endfunction

endpackage

// File: rtl/csm_cell.sv
module csm_cell
  import sqrt_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic b,
  input  logic keep_x,
  output logic d,
  output logic bo
);

  csm_out_t res;

  always_comb begin
    res = csm_eval(x, y, b, keep_x);
    d   = res.d;
    bo  = res.bo;
  end

endmodule

// File: rtl/sqrt_row.sv
module sqrt_row #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] d,
  output logic         borrow
);

  // Ripple borrow chain; the top borrow steers every cell's multiplexer.
  logic [W:0] bchain;
  logic       keep_x;

  assign bchain[0] = 1'b0;
  assign keep_x    = bchain[W];
  assign borrow    = bchain[W];

  for (genvar i = 0; i < W; i++) begin : g_cell
    csm_cell u_cell (
      .x      (x[i]),
      .y      (y[i]),
      .b      (bchain[i]),
      .keep_x (keep_x),
      .d      (d[i]),
      .bo     (bchain[i+1])
    );
  end

endmodule

// File: rtl/sqrt_stage.sv
module sqrt_stage
  import sqrt_pkg::*;
#(
  parameter int unsigned RAD_W  = 16,
  parameter int unsigned ROOT_W = RAD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [RAD_W-1:0]  in_rad,
  input  logic [ROOT_W:0]   in_rem,
  input  logic [ROOT_W-1:0] in_root,
  output logic              take,
  output logic              out_valid,
  output logic [RAD_W-1:0]  out_rad,
  output logic [ROOT_W:0]   out_rem,
  output logic [ROOT_W-1:0] out_root
);

  localparam int unsigned ROW_W = ROOT_W + 2;

  logic [ROW_W-1:0] row_x;
  logic [ROW_W-1:0] row_y;
  logic [ROW_W-1:0] row_d;
  logic [63:0]      trial_full;
  logic             row_borrow;

  // Incoming remainder is below 2^ROOT_W, so its top bit is dropped here.
  assign row_x      = {in_rem[ROOT_W-1:0], in_rad[RAD_W-1 -: 2]};
  assign trial_full = trial_of(64'(in_root));
  assign row_y      = trial_full[ROW_W-1:0];

  sqrt_row #(.W(ROW_W)) u_row (
    .x      (row_x),
    .y      (row_y),
    .d      (row_d),
    .borrow (row_borrow)
  );

  assign take = ~row_borrow;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    out_rad  <= {in_rad[RAD_W-3:0], 2'b00};
    out_rem  <= row_d[ROOT_W:0];
    out_root <= {in_root[ROOT_W-2:0], take};
  end

endmodule

// File: rtl/sqrt_pipe.sv
module sqrt_pipe #(
  parameter int unsigned RAD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [RAD_W-1:0]     in_rad,
  output logic                 out_valid,
  output logic [RAD_W/2-1:0]   out_root,
  output logic [RAD_W/2:0]     out_rem
);

  localparam int unsigned ROOT_W = RAD_W / 2;
  localparam int unsigned NST    = ROOT_W;

  // Per-boundary state: index 0 is the block input, index k+1 the register of row k.
  logic              vld  [NST+1];
  logic [RAD_W-1:0]  rad  [NST+1];
  logic [ROOT_W:0]   rem  [NST+1];
  logic [ROOT_W-1:0] root [NST+1];

  // Named internal events for the checker.
  logic [NST-1:0] stage_take;
  logic [NST-1:0] stage_vld;
  logic [NST-1:0] stage_rem_msb;

  assign vld[0]  = in_valid;
  assign rad[0]  = in_rad;
  assign rem[0]  = '0;
  assign root[0] = '0;

  for (genvar k = 0; k < NST; k++) begin : g_stage
    sqrt_stage #(.RAD_W(RAD_W), .ROOT_W(ROOT_W)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (vld[k]),
      .in_rad    (rad[k]),
      .in_rem    (rem[k]),
      .in_root   (root[k]),
      .take      (stage_take[k]),
      .out_valid (vld[k+1]),
      .out_rad   (rad[k+1]),
      .out_rem   (rem[k+1]),
      .out_root  (root[k+1])
    );
    assign stage_vld[k]     = vld[k+1];
    assign stage_rem_msb[k] = rem[k+1][ROOT_W];
  end

  assign out_valid = vld[NST];
  assign out_root  = root[NST];
  assign out_rem   = rem[NST];

endmodule

// File: rtl/sqrt_pipe_chk.sv
module sqrt_pipe_chk #(
  parameter int unsigned RAD_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [RAD_W-1:0]     in_rad,
  input logic                 out_valid,
  input logic [RAD_W/2-1:0]   out_root,
  input logic [RAD_W/2:0]     out_rem,
  input logic [RAD_W/2-1:0]   stage_vld,
  input logic [RAD_W/2-1:0]   stage_rem_msb
);

  localparam int unsigned ROOT_W = RAD_W / 2;

  // Independent delay line of sampled inputs.
  logic [ROOT_W-1:0] vsh;
  logic [RAD_W-1:0]  dsh [ROOT_W];
  logic [RAD_W:0]    recon;
  logic [RAD_W:0]    twice_root;

  always_ff @(posedge clk) begin
    if (rst) vsh <= '0;
    else     vsh <= {vsh[ROOT_W-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    dsh[0] <= in_rad;
    for (int i = 1; i < ROOT_W; i++) dsh[i] <= dsh[i-1];
  end

  always_comb begin
    recon      = (RAD_W+1)'(out_root) * (RAD_W+1)'(out_root) + (RAD_W+1)'(out_rem);
    twice_root = (RAD_W+1)'(out_root) << 1;
  end

  AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[ROOT_W-1]);  // R3

  AST_ROOT_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> recon == {1'b0, dsh[ROOT_W-1]});  // R2

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (RAD_W+1)'(out_rem) <= twice_root);  // R4

  AST_INNER_REM_FITS: assert property (@(posedge clk) disable iff (rst)
    (stage_vld[ROOT_W-2:0] & stage_rem_msb[ROOT_W-2:0]) == '0);  // R4

  AST_RESET_FLUSH: assert property (@(posedge clk)
    rst |=> !out_valid);  // R6

endmodule

bind sqrt_pipe sqrt_pipe_chk #(.RAD_W(RAD_W)) u_sqrt_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_rad        (in_rad),
  .out_valid     (out_valid),
  .out_root      (out_root),
  .out_rem       (out_rem),
  .stage_vld     (stage_vld),
  .stage_rem_msb (stage_rem_msb)
);

// File: tb/tb_sqrt_pipe.sv
module tb_sqrt_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 16;
  localparam int SW = 8;
  localparam int BN = BW / 2;
  localparam int SN = SW / 2;

  typedef struct {
    int    rad;
    int    root;
    int    rem;
    int    due;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic              b_vin = 1'b0;
  logic [BW-1:0]     b_rad = '0;
  logic              b_vout;
  logic [BN-1:0]     b_root;
  logic [BN:0]       b_rem;
  logic              s_vin = 1'b0;
  logic [SW-1:0]     s_rad = '0;
  logic              s_vout;
  logic [SN-1:0]     s_root;
  logic [SN:0]       s_rem;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  exp_t bq[$];
  exp_t sq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sqrt_pipe #(.RAD_W(BW)) dut (
    .clk(clk), .rst(rst), .in_valid(b_vin), .in_rad(b_rad),
    .out_valid(b_vout), .out_root(b_root), .out_rem(b_rem));

  sqrt_pipe #(.RAD_W(SW)) dut_small (
    .clk(clk), .rst(rst), .in_valid(s_vin), .in_rad(s_rad),
    .out_valid(s_vout), .out_root(s_root), .out_rem(s_rem));

  // Reference: largest r with r*r <= v, found by bit-wise search.
  function automatic int ref_root(input int v);
    int r = 0;
    for (int b = 15; b >= 0; b--) begin
      int t = r | (1 << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  function automatic exp_t mk(input int v, input int lat);
    exp_t e;
    e.rad  = v;
    e.root = ref_root(v);
    e.rem  = v - e.root * e.root;
    e.due  = cyc + lat;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Driver: one cycle of stimulus on both pipes, pushing expectations.
  task automatic step(input bit bv, input int bd, input bit sv, input int sd);
    @(negedge clk);
    b_vin = bv; b_rad = BW'(bd);
    s_vin = sv; s_rad = SW'(sd);
    if (!rst && bv) bq.push_back(mk(bd, BN));
    if (!rst && sv) sq.push_back(mk(sd, SN));
  endtask

  task automatic compare(input exp_t e, input int root, input int rem, input int maxv);
    check(root == e.root, "R1 root", root, e.root);
    check(rem == e.rem, "R2 remainder", rem, e.rem);
    check(cyc == e.due, "R3 latency", cyc, e.due);
    check(rem <= 2 * root, "R4 remainder bound", rem, 2 * root);
    if (e.rad == 0 || e.rad == maxv)
      check(root == e.root && rem == e.rem, "R7 extreme radicand", root, e.root);
    if (e.rem == 0)
      check(rem == 0, "R8 perfect square", rem, 0);
  endtask

  // Monitor: pop and compare whenever a pipe produces a result.
  always @(negedge clk) begin
    if (!rst) begin
      if (b_vout) begin
        if (bq.size() == 0) check(1'b0, "R5 spurious wide result", 1, 0);
        else compare(bq.pop_front(), int'(b_root), int'(b_rem), 65535);
      end
      if (s_vout) begin
        if (sq.size() == 0) check(1'b0, "R5 spurious narrow result", 1, 0);
        else compare(sq.pop_front(), int'(s_root), int'(s_rem), 255);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    // R6: traffic during reset must vanish.
    rst = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 1000 + i, 1'b1, 17 + i);
    @(negedge clk);
    check(b_vout == 1'b0 && s_vout == 1'b0, "R6 reset clears valid", int'(b_vout), 0);
    rst = 1'b0;
    b_vin = 1'b0; s_vin = 1'b0;
    for (int i = 0; i < BN + 2; i++) begin
      step(1'b0, 0, 1'b0, 0);
      check(b_vout == 1'b0 && s_vout == 1'b0, "R6 idle after reset", int'(b_vout | s_vout), 0);
    end

    // Exhaustive narrow radicands, random wide ones, streaming back to back.
    for (int v = 0; v < 256; v++) step(1'b1, $urandom_range(65535), 1'b1, v);

    // R5: bubbles between corner values; R7, R8 corners.
    step(1'b1, 0, 1'b0, 0);
    step(1'b0, 0, 1'b0, 0);
    step(1'b1, 65535, 1'b1, 255);
    step(1'b0, 0, 1'b0, 0);
    step(1'b0, 0, 1'b1, 0);
    step(1'b1, 65025, 1'b0, 0);
    step(1'b1, 1, 1'b1, 225);
    step(1'b0, 0, 1'b0, 0);
    step(1'b1, 10000, 1'b1, 1);
    step(1'b1, 65024, 1'b1, 224);
    step(1'b1, 16384, 1'b1, 64);
    step(1'b1, 2, 1'b1, 3);

    // Random mixed traffic with sparse idle cycles.
    for (int i = 0; i < 600; i++)
      step(($urandom_range(7) != 0), $urandom_range(65535),
           ($urandom_range(5) != 0), $urandom_range(255));

    // Drain and confirm every expected result arrived.
    for (int i = 0; i < BN + 4; i++) step(1'b0, 0, 1'b0, 0);
    check(bq.size() == 0, "R3 wide results all delivered", bq.size(), 0);
    check(sq.size() == 0, "R3 narrow results all delivered", sq.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule